// File: doc/BRIEF.md
# Byte-Strobe Message Packer with Length Counter

This block sits between a 32-bit write port and a hash engine. Each write carries data, byte strobes and the two lowest address bits of a message window. The block picks out the bytes the write really carries and puts them in message order. When swapping is enabled, a write of two or more bytes is reversed. The bytes are then packed into 32-bit words. Each complete word goes into a word FIFO, and the hash engine drains that FIFO through a pop input.

Bytes left over from a write wait in a small carry register until later writes complete the word. The block counts the message length in bits and reports the FIFO's empty, full and occupancy state. A write that arrives while the FIFO is full is held with a low ready until space frees up. The length counter can be loaded while the engine is disabled, so that a saved context can be restored.

Top module: `msg_packer`

## Requirements
- R1: After reset the FIFO is empty (empty=1, full=0, depth=0), the length is 0 and ready is 1.
- R2: A byte lane i (data bits 8i+7..8i) is carried when its strobe is set and i is at least the write's address offset addr[1:0]. Strobed lanes below the offset are discarded.
- R3: With swapping off, the carried bytes are appended from the lowest lane up. The first message byte of each FIFO word sits in bits 7..0, and later bytes fill bits 15..8, 23..16 and 31..24.
- R4: With swapping on, a write carrying two or more bytes is appended from the highest carried lane down, whatever its offset.
- R5: A write carrying exactly one byte appends that byte the same way whether swapping is on or off.
- R6: Bytes that do not complete a word are held and combined with the bytes of later writes. One write pushes at most one word, and the word is at the FIFO output in the cycle after the accepting clock edge.
- R7: The FIFO holds 32 words in order. The depth output counts the stored words, and a pop while empty has no effect.
- R8: While the FIFO holds 32 words, ready is low, so a pending write is neither lost nor accepted. It is accepted once a pop frees a slot.
- R9: Each accepted write adds 8 times the number of carried bytes to the 64-bit bit length.
- R10: A length load while the engine enable is low replaces the length with the loaded value, its low three bits forced to zero, and takes priority over a write in the same cycle. A load while the enable is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write accepted when high together with valid |
| wr_addr_i | input | 2 | Byte offset of the write in the window |
| wr_strb_i | input | 4 | Byte strobes |
| wr_data_i | input | 32 | Write data |
| endian_swap_i | input | 1 | Reverse the byte order of multi-byte writes |
| engine_en_i | input | 1 | Hash engine enabled; blocks length loads |
| len_load_i | input | 1 | Load the length counter |
| len_load_val_i | input | 64 | Value for the length load |
| pop_i | input | 1 | Hash engine takes the head word |
| fifo_data_o | output | 32 | Head word of the FIFO |
| fifo_valid_o | output | 1 | Head word is valid |
| fifo_empty_o | output | 1 | FIFO holds no word |
| fifo_full_o | output | 1 | FIFO holds 32 words |
| fifo_depth_o | output | 6 | Number of stored words |
| msg_len_o | output | 64 | Message length in bits |

## Verification
The bench aims at byte ordering. It mixes swapped and unswapped halfword writes at offset 2 with single-byte writes. A packer that ignored the swap would show a byte-reversed head word, and one that swapped single bytes would misplace lanes. A write with full strobes at offset 2 shows whether the low lanes are dropped. A design that kept them would count 16 extra bits of length and misalign every later word. The bench also holds a write against a full FIFO, where a design that dropped or overwrote the data would lose a word or corrupt the head. Finally it loads the length with the engine enabled and together with a write, where a wrong priority shows up as a length off by the write's bit count.

// File: rtl/msg_packer.sv
module msg_packer #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int LW    = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [1:0]    wr_addr_i,
  input  logic [3:0]    wr_strb_i,
  input  logic [31:0]   wr_data_i,
  input  logic          endian_swap_i,
  input  logic          engine_en_i,
  input  logic          len_load_i,
  input  logic [63:0]   len_load_val_i,
  input  logic          pop_i,
  output logic [31:0]   fifo_data_o,
  output logic          fifo_valid_o,
  output logic          fifo_empty_o,
  output logic          fifo_full_o,
  output logic [5:0]    fifo_depth_o,
  output logic [63:0]   msg_len_o
);
  localparam int NB   = DW / 8;
  localparam int OFFW = $clog2(NB);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int SW   = 2 * DW - 8;

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   cnt;
  logic [DW-9:0]   pk_data;
  logic [OFFW-1:0] pk_cnt;
  logic [LW-1:0]   len_q;

  logic [NB-1:0]   lane_en;
  logic [OFFW:0]   nbytes;
  logic [DW-1:0]   ordered;
  logic [SW-1:0]   stream;
  logic [OFFW:0]   total;
  logic            accept, push, pop_eff, load_ok;

  assign wr_ready_o = cnt != CW'(DEPTH);
  assign accept     = wr_valid_i && wr_ready_o;
  assign pop_eff    = pop_i && cnt != '0;
  assign load_ok    = len_load_i && !engine_en_i;

  always_comb begin
    int k;
    int li;
    logic big;
    for (int i = 0; i < NB; i++)
      lane_en[i] = wr_strb_i[i] && (i >= int'(wr_addr_i));
    nbytes  = (OFFW+1)'($countones(lane_en));
    big     = endian_swap_i && nbytes > (OFFW+1)'(1);
    ordered = '0;
    k = 0;
    for (int j = 0; j < NB; j++) begin
      li = big ? NB - 1 - j : j;
      if (lane_en[li]) begin
        ordered[8*k +: 8] = wr_data_i[8*li +: 8];
        k++;
      end
    end
    stream = {{DW{1'b0}}, pk_data} | ({{(DW-8){1'b0}}, ordered} << (8 * int'(pk_cnt)));
    total  = (OFFW+1)'(pk_cnt) + nbytes;
  end

  assign push = accept && total >= (OFFW+1)'(NB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_data <= '0;
      pk_cnt  <= '0;
    end else if (accept) begin
      pk_data <= push ? stream[SW-1:DW] : stream[DW-9:0];
      pk_cnt  <= total[OFFW-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr] <= stream[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push)    wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop_eff) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop_eff);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (load_ok) len_q <= {len_load_val_i[LW-1:3], 3'b000};
    else if (accept)  len_q <= len_q + LW'({nbytes, 3'b000});
  end

  assign fifo_data_o  = mem[rptr];
  assign fifo_empty_o = cnt == '0;
  assign fifo_valid_o = !fifo_empty_o;
  assign fifo_full_o  = !wr_ready_o;
  assign fifo_depth_o = 6'(cnt);
  assign msg_len_o    = len_q;

  a_r7_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  a_r7_pop_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !fifo_empty_o && !push) |=> fifo_depth_o == $past(fifo_depth_o) - 6'd1);
  a_r8_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && !pop_i) |=> fifo_full_o);
  a_r7_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_valid_o && !pop_i) |=> $stable(fifo_data_o));
  a_r9_len_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_valid_i && !len_load_i) |=> $stable(msg_len_o));
  a_r10_load_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_load_i && engine_en_i && !wr_valid_i) |=> $stable(msg_len_o));
  a_r6_one_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && wr_valid_i && wr_ready_o) |=> fifo_depth_o - $past(fifo_depth_o) <= 6'd1);
endmodule

// File: tb/msg_packer_tb.sv
module msg_packer_tb;
  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, swap = 0, en = 0, ld = 0, pop = 0;
  logic [1:0]  addr = 0;
  logic [3:0]  strb = 0;
  logic [31:0] data = 0;
  logic [63:0] ldval = 0;
  logic        wr_ready, f_valid, f_empty, f_full;
  logic [31:0] f_data;
  logic [5:0]  f_depth;
  logic [63:0] mlen;

  int nchk = 0, nerr = 0;
  logic [7:0]  pend[$];
  logic [31:0] wq[$];
  logic [63:0] m_len;
  bit          cmp_on = 0;

  always #2 clk = ~clk;

  msg_packer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(addr), .wr_strb_i(strb), .wr_data_i(data), .endian_swap_i(swap),
    .engine_en_i(en), .len_load_i(ld), .len_load_val_i(ldval), .pop_i(pop),
    .fifo_data_o(f_data), .fifo_valid_o(f_valid), .fifo_empty_o(f_empty),
    .fifo_full_o(f_full), .fifo_depth_o(f_depth), .msg_len_o(mlen));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pend.delete(); wq.delete(); m_len = 0;
    end else begin
      bit acc, popd;
      int n, li;
      acc  = wr_valid && wq.size() < 32;
      popd = pop && wq.size() > 0;
      if (popd) void'(wq.pop_front());
      n = 0;
      for (int i = 0; i < 4; i++) if (strb[i] && i >= int'(addr)) n++;
      if (acc) begin
        for (int j = 0; j < 4; j++) begin
          li = (swap && n > 1) ? 3 - j : j;
          if (strb[li] && li >= int'(addr)) pend.push_back(data[8*li +: 8]);
        end
        while (pend.size() >= 4) begin
          wq.push_back({pend[3], pend[2], pend[1], pend[0]});
          repeat (4) void'(pend.pop_front());
        end
      end
      if (ld && !en) m_len = {ldval[63:3], 3'b000};
      else if (acc) m_len = m_len + 64'(8 * n);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(f_depth == 6'(wq.size()), "R7 depth", f_depth, wq.size());
      chk(f_empty == (wq.size() == 0), "R7 empty", f_empty, wq.size() == 0);
      chk(f_full == (wq.size() == 32), "R7 full", f_full, wq.size() == 32);
      chk(wr_ready == (wq.size() < 32), "R8 ready", wr_ready, wq.size() < 32);
      chk(mlen == m_len, "R9 length", mlen, m_len);
      if (wq.size() > 0) chk(f_data == wq[0], "R3 head word", f_data, wq[0]);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
    bit rdy;
    @(negedge clk);
    wr_valid = 1; addr = a; strb = s; data = d;
    forever begin
      rdy = wr_ready;
      @(negedge clk);
      if (rdy) break;
    end
    wr_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    pop = 1;
    while (!f_empty) @(negedge clk);
    pop = 0;
  endtask

  initial begin
    logic [63:0] l0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(f_empty && !f_full && f_depth == 0 && mlen == 0 && wr_ready, "R1 reset state",
        {f_empty, f_full, f_depth}, {1'b1, 1'b0, 6'd0});
    cmp_on = 1;

    swap = 0; wr(2'd0, 4'hF, 32'h03020100);
    chk(f_data == 32'h03020100, "R3 word unswapped", f_data, 32'h03020100);
    drain();

    swap = 1; wr(2'd0, 4'hF, 32'hAABBCCDD);
    chk(f_data == 32'hDDCCBBAA, "R4 word swapped", f_data, 32'hDDCCBBAA);
    drain();

    wr(2'd2, 4'b0100, 32'h00110000);
    wr(2'd0, 4'b0001, 32'h00000022);
    wr(2'd3, 4'b1000, 32'h33000000);
    wr(2'd1, 4'b0010, 32'h00004400);
    chk(f_data == 32'h44332211, "R5 single bytes under swap", f_data, 32'h44332211);
    drain();

    wr(2'd2, 4'b1100, 32'h12340000);
    chk(f_depth == 0, "R6 partial held", f_depth, 0);
    swap = 0; wr(2'd0, 4'b0011, 32'h00005678);
    chk(f_data == 32'h56783412 && f_depth == 1, "R4 R6 halfword mix", f_data, 32'h56783412);
    drain();

    l0 = mlen;
    wr(2'd2, 4'hF, 32'h44332211);
    chk(mlen == l0 + 16, "R9 R2 length of offset write", mlen, l0 + 16);
    wr(2'd0, 4'b0011, 32'h0000BBAA);
    chk(f_data == 32'hBBAA4433, "R2 low lanes dropped", f_data, 32'hBBAA4433);
    drain();

    for (int i = 0; i < 32; i++) wr(2'd0, 4'hF, 32'h100 + i);
    chk(f_full && f_depth == 32, "R7 fills to 32", f_depth, 32);
    fork
      wr(2'd0, 4'hF, 32'hFEEDFACE);
      begin
        repeat (5) begin
          @(negedge clk);
          chk(!wr_ready && f_depth == 32, "R8 stalled while full", wr_ready, 0);
        end
        pop = 1; @(negedge clk); pop = 0;
      end
    join
    chk(f_depth == 32 && f_data == 32'h101, "R8 held write accepted", f_data, 32'h101);
    drain();
    pop = 1; repeat (3) @(negedge clk); pop = 0;
    chk(f_empty && f_depth == 0, "R7 pop when empty ignored", f_depth, 0);

    l0 = mlen;
    en = 1; ldval = 64'h1234; ld = 1; @(negedge clk); ld = 0; @(negedge clk);
    chk(mlen == l0, "R10 load ignored while enabled", mlen, l0);
    en = 0; ldval = 64'h0000_0001_0000_00FF; ld = 1; @(negedge clk); ld = 0; @(negedge clk);
    chk(mlen == 64'h0000_0001_0000_00F8, "R10 load low bits cleared", mlen, 64'h0000_0001_0000_00F8);
    ldval = 64'h40; ld = 1; wr(2'd0, 4'hF, 32'h0); ld = 0;
    chk(mlen == 64'h40, "R10 load beats write", mlen, 64'h40);
    wr(2'd0, 4'hF, 32'h0);
    chk(mlen == 64'h60, "R9 word adds 32", mlen, 64'h60);
    pop = 1;
    wr(2'd0, 4'hF, 32'h5);
    pop = 0;
    drain();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #80000;
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule